// File: doc/BRIEF.md
# Bidirectional Edge-Pulse Isolation Channel Controller

This block is the digital control of a two-channel isolated link, with one channel running in each direction. A side sends its input level across as pulses: a rising edge becomes a set command and a falling edge becomes a clear command. A set/clear latch on the far side rebuilds the level from these commands. Sending pulses instead of a level has a cost. A command that reaches a receiver while that receiver cannot accept it is lost, and the output stays stale until the next edge or until the transmitter resends its level.

Each side has three synchronous control inputs: an enable, a raw undervoltage flag and a data input. Together they decide, for each output, whether it follows its input, is forced low, or holds its last value.

The raw undervoltage flag only takes effect after it has stayed high for a masking time. Shorter drops are ignored. When the undervoltage state clears, that side's input is ignored for an inhibit window. Once the side becomes able to send again, it sends its current level one time.

Side s owns bit s of `din`, `en` and `uv_raw`. `dout[s]` is the output of the channel whose input is `din[s]`, rebuilt on side 1-s.

Top module: `iso_bidir_ctrl`

## Requirements
- R1: With both sides enabled and out of undervoltage, `dout[s]` takes the value of `din[s]`. The change appears at the third rising clock edge, counting the first edge that samples the new input.
- R2: When `en[0]` and `en[1]` are both low, both outputs are low from the next clock edge.
- R3: When `en[r]` is low, `dout[1-r]` (the channel received on side r) is cleared to low at the next edge. It stays low after the enable returns until a set command arrives.
- R4: When `en[s]` is low, `dout[s]` holds its value and edges on `din[s]` are not sent.
- R5: While side s is in undervoltage, `dout[s]` is cleared to low and `dout[1-s]` holds its value.
- R6: Side s enters undervoltage only at the clock edge that samples `uv_raw[s]` high for the MASK_CYC-th consecutive time. A shorter high run has no effect on either output.
- R7: When side s leaves undervoltage, edges on `din[s]` are ignored for INH_CYC clock cycles.
- R8: A command that reaches a receiver side while that side is in undervoltage is dropped. The output keeps its stale value after recovery until a later command arrives.
- R9: When side s becomes able to send (enabled, out of undervoltage, inhibit window over), it sends its current synchronized level once: a set command if the level is 1, a clear command if it is 0.
- R10: Synchronous reset clears both outputs and the synchronizers, and puts both sides in undervoltage with no inhibit pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 2 | Channel inputs, bit s on side s (asynchronous, synchronized inside) |
| en | input | 2 | Per-side enable, active high |
| uv_raw | input | 2 | Per-side raw undervoltage flag, active high, synchronous |
| dout | output | 2 | Rebuilt channel outputs, bit s is the channel fed by din[s] |

## Verification
The bench builds the block with MASK_CYC = 4 and INH_CYC = 6. With these values the masking threshold, a glitch one cycle short of it, and the full inhibit window all fit in a few dozen cycles. This also puts within reach the supply-order startup cases, where the second side recovers after the first side's resend has already been dropped. A behavioural model compares both outputs on every clock. Directed checks also sample the held, forced and stale states between stimuli.

// File: rtl/iso_link_pkg.sv
`timescale 1ns/1ps
package iso_link_pkg;
   localparam int unsigned NSIDE = 2;

   typedef struct packed {
      logic set;
      logic clr;
   } edge_cmd_t;
endpackage

// File: rtl/iso_edge_tx.sv
`timescale 1ns/1ps
module iso_edge_tx
   import iso_link_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      pin,
   input  logic      live,
   input  logic      fresh,
   output edge_cmd_t cmd
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("iso_edge_tx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sh;
   logic                   prev;
   logic                   lvl, rise, fall;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[SYNC_STAGES-2:0], pin};
         prev <= sh[TOP];
      end
   end

   assign lvl  = sh[TOP];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      cmd.set = live & (rise | (fresh & lvl));
      cmd.clr = live & (fall | (fresh & ~lvl));
   end

   // R1: an edge marker lasts one cycle only
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/iso_side_guard.sv
`timescale 1ns/1ps
module iso_side_guard #(
   parameter int unsigned MASK_CYC = 1250,
   parameter int unsigned INH_CYC  = 62500
) (
   input  logic clk,
   input  logic rst,
   input  logic uv_raw,
   input  logic en,
   output logic uv_on,
   output logic live,
   output logic fresh
);
   localparam int unsigned CW = $clog2(MASK_CYC + 1);
   localparam int unsigned IW = $clog2(INH_CYC + 1);
   localparam logic [CW-1:0] MASK_LAST = CW'(MASK_CYC - 1);
   localparam logic [IW-1:0] INH_LOAD  = IW'(INH_CYC);

   generate
      if (MASK_CYC < 1) begin : g_bad_mask
         $error("iso_side_guard: MASK_CYC must be at least 1");
      end
      if (INH_CYC < 1) begin : g_bad_inh
         $error("iso_side_guard: INH_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [IW-1:0] inh;
   logic          uv_q, live_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         uv_q   <= 1'b1;
         inh    <= '0;
         live_q <= 1'b0;
      end else begin
         live_q <= live;
         if (uv_raw) begin
            if (cnt == MASK_LAST) uv_q <= 1'b1;
            else                  cnt  <= cnt + 1'b1;
         end else begin
            cnt  <= '0;
            uv_q <= 1'b0;
         end
         if (!uv_raw && uv_q)  inh <= INH_LOAD;
         else if (inh != '0)   inh <= inh - 1'b1;
      end
   end

   assign uv_on = uv_q;
   assign live  = ~uv_q & (inh == '0) & en;
   assign fresh = live & ~live_q;

   // R6: undervoltage is only entered while the raw flag was high
   a_r6_mask_entry: assert property (@(posedge clk) disable iff (rst)
      $rose(uv_q) |-> $past(uv_raw));
   // R7: a side leaving undervoltage does not send in that cycle
   a_r7_inhibit_start: assert property (@(posedge clk) disable iff (rst)
      $fell(uv_q) |-> !live);
endmodule

// File: rtl/iso_rx_latch.sv
`timescale 1ns/1ps
module iso_rx_latch
   import iso_link_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  edge_cmd_t cmd,
   input  logic      force_low,
   input  logic      rx_up,
   output logic      q
);
   always_ff @(posedge clk) begin
      if (rst)             q <= 1'b0;
      else if (force_low)  q <= 1'b0;
      else if (rx_up) begin
         if (cmd.set)      q <= 1'b1;
         else if (cmd.clr) q <= 1'b0;
      end
   end

   // R3: a forced channel is low one edge later
   a_r3_forced_low: assert property (@(posedge clk) disable iff (rst)
      force_low |=> !q);
   // R5: a receiver in undervoltage keeps its value
   a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
      (!force_low && !rx_up) |=> $stable(q));
endmodule

// File: rtl/iso_bidir_ctrl.sv
`timescale 1ns/1ps
module iso_bidir_ctrl
   import iso_link_pkg::*;
#(
   parameter int unsigned MASK_CYC    = 1250,
   parameter int unsigned INH_CYC     = 62500,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] din,
   input  logic [1:0] en,
   input  logic [1:0] uv_raw,
   output logic [1:0] dout
);
   logic [NSIDE-1:0] uv_on, live, fresh;
   edge_cmd_t        cmd [NSIDE];

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      localparam int unsigned R = NSIDE - 1 - s;

      iso_side_guard #(.MASK_CYC(MASK_CYC), .INH_CYC(INH_CYC)) u_guard (
         .clk(clk), .rst(rst), .uv_raw(uv_raw[s]), .en(en[s]),
         .uv_on(uv_on[s]), .live(live[s]), .fresh(fresh[s]));

      iso_edge_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
         .clk(clk), .rst(rst), .pin(din[s]), .live(live[s]),
         .fresh(fresh[s]), .cmd(cmd[s]));

      iso_rx_latch u_rx (
         .clk(clk), .rst(rst), .cmd(cmd[s]),
         .force_low(~en[R] | uv_on[s]), .rx_up(~uv_on[R]),
         .q(dout[s]));
   end

   // R2: both sides disabled clears both outputs
   a_r2_both_off: assert property (@(posedge clk) disable iff (rst)
      (!en[0] && !en[1]) |=> (dout == 2'b00));
endmodule

// File: tb/iso_bidir_ctrl_test.sv
`timescale 1ns/1ps
module iso_bidir_ctrl_test;
   localparam int MASK = 4;
   localparam int INH  = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] din = 2'b00;
   logic [1:0] en  = 2'b11;
   logic [1:0] uv  = 2'b11;
   logic [1:0] dout;

   int checks = 0;
   int errors = 0;
   bit started = 0;
   bit done = 0;

   iso_bidir_ctrl #(.MASK_CYC(MASK), .INH_CYC(INH), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .din(din), .en(en), .uv_raw(uv), .dout(dout));

   always #4 clk = ~clk;

   // behavioural reference model
   int m_s1[2], m_s2[2], m_prev[2], m_run[2], m_uv[2], m_inh[2], m_act[2];
   int t_act[2], t_fr[2];
   logic [1:0] m_q;

   always @(posedge clk) begin
      started = 1;
      if (rst) begin
         for (int s = 0; s < 2; s++) begin
            m_s1[s] = 0; m_s2[s] = 0; m_prev[s] = 0; m_run[s] = 0;
            m_uv[s] = 1; m_inh[s] = 0; m_act[s] = 0;
         end
         m_q = 2'b00;
      end else begin
         for (int s = 0; s < 2; s++) begin
            t_act[s] = (m_uv[s] == 0 && m_inh[s] == 0 && en[s]) ? 1 : 0;
            t_fr[s]  = (t_act[s] == 1 && m_act[s] == 0) ? 1 : 0;
         end
         for (int s = 0; s < 2; s++) begin
            int r;
            bit up, dn;
            r  = 1 - s;
            up = (m_s2[s] == 1 && m_prev[s] == 0) || (t_fr[s] == 1 && m_s2[s] == 1);
            dn = (m_s2[s] == 0 && m_prev[s] == 1) || (t_fr[s] == 1 && m_s2[s] == 0);
            if (!en[r] || m_uv[s] == 1) m_q[s] = 1'b0;
            else if (m_uv[r] == 0 && t_act[s] == 1) begin
               if (up)      m_q[s] = 1'b1;
               else if (dn) m_q[s] = 1'b0;
            end
         end
         for (int s = 0; s < 2; s++) begin
            m_act[s]  = t_act[s];
            m_prev[s] = m_s2[s];
            m_s2[s]   = m_s1[s];
            m_s1[s]   = din[s] ? 1 : 0;
            if (uv[s]) begin
               if (m_run[s] + 1 >= MASK) m_uv[s] = 1;
               if (m_run[s] < MASK) m_run[s]++;
               if (m_inh[s] > 0) m_inh[s]--;
            end else begin
               if (m_uv[s] == 1)     m_inh[s] = INH;
               else if (m_inh[s] > 0) m_inh[s]--;
               m_uv[s]  = 0;
               m_run[s] = 0;
            end
         end
      end
   end

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dout=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model (R1 R3 R4 R5 R7 R8 R9)
   always @(negedge clk) begin
      if (started && !done) check("model R1 R5 R9", dout, m_q);
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cyc(3);
      check("R10 reset", dout, 2'b00);
      rst = 1'b0;
      din = 2'b11;
      cyc(6);
      check("R10 starts in undervoltage", dout, 2'b00);
      din = 2'b00;
      cyc(2);
      uv = 2'b00;
      cyc(15);
      check("R9 startup levels low", dout, 2'b00);

      din = 2'b01; cyc(4); check("R1 ch0 rise", dout, 2'b01);
      din = 2'b00; cyc(4); check("R1 ch0 fall", dout, 2'b00);
      din = 2'b10; cyc(4); check("R1 ch1 rise", dout, 2'b10);
      din = 2'b11; cyc(4); check("R1 both high", dout, 2'b11);

      en = 2'b10; cyc(4); check("R3 side0 disabled clears dout1", dout, 2'b01);
      din = 2'b10; cyc(4); check("R4 side0 edge not sent", dout, 2'b01);
      en = 2'b00; cyc(3); check("R2 both disabled", dout, 2'b00);
      din = 2'b01; cyc(4);
      en = 2'b11; cyc(4); check("R9 resend on enable", dout, 2'b01);

      uv = 2'b10; cyc(MASK - 1);
      uv = 2'b00; cyc(3); check("R6 short glitch ignored", dout, 2'b01);
      din = 2'b00; cyc(4); check("R6 link still live", dout, 2'b00);
      din = 2'b11; cyc(4); check("R1 both rise", dout, 2'b11);

      uv = 2'b10; cyc(7); check("R5 side1 undervoltage", dout, 2'b01);
      din = 2'b10; cyc(4); check("R5 dout0 held", dout, 2'b01);
      uv = 2'b00; cyc(3); check("R7 inhibit window", dout, 2'b01);
      cyc(12); check("R8 stale dout0 R9 resend dout1", dout, 2'b11);
      din = 2'b00; cyc(4); check("R1 ch1 fall", dout, 2'b01);
      din = 2'b01; cyc(4);
      din = 2'b00; cyc(4); check("R8 cleared by new edge", dout, 2'b00);

      rst = 1'b1; uv = 2'b11; din = 2'b11; cyc(3);
      check("R10 mid-run reset", dout, 2'b00);
      rst = 1'b0; cyc(6);
      uv = 2'b01; cyc(15); check("R8 side1 first", dout, 2'b00);
      uv = 2'b00; cyc(15); check("R8 resend lost R9 resend taken", dout, 2'b01);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule